// File: doc/BRIEF.md
# 4:2:2 Pixel Output Formatter

This block sits at the end of a video capture path and turns a full-resolution YUV 4:4:4 pixel stream, one pixel per clock, into a two-lane 4:2:2 stream. The luma lane carries Y for every pixel. The chroma lane alternates between a U sample and a V sample. Both chroma samples of a pair come from the even pixel of that pair, so the chroma is co-sited. The chroma of the odd pixel is dropped.

All outputs leave through a fixed pipeline of LAT register stages (default 8). The horizontal sync marker and the data-valid flag go through the same pipeline, so sync, valid, luma, chroma and the chroma phase flag always belong to the same pixel. The pairing restarts at every rising edge of the sync input, so each line begins with a U sample. Invalid cycles still move through the pipeline, but they do not advance the U/V pairing.

Top module: `fmt422_out`

## Requirements
- R1: The Y byte of a valid pixel sampled at rising edge n is on `out_y` right after edge n+LAT-1 (LAT register stages, default 8), with `out_valid` high.
- R2: For a pixel taken as the even (U) member of a pair, `out_c` carries that pixel's U byte and `out_cphase` is 0.
- R3: For a pixel taken as the odd (V) member of a pair, `out_c` carries the V byte of the preceding even pixel and `out_cphase` is 1. The odd pixel's own U and V bytes appear nowhere on the outputs.
- R4: Successive valid pixels alternate U, V, U, V. A cycle with `in_valid` low does not advance the pairing, and a V output is always preceded by a U output.
- R5: When `in_hs` is high and was low at the previous sampled edge, the valid pixel in that cycle, or else the first later valid pixel, is taken as a U pixel.
- R6: `out_hs` equals `in_hs` delayed by the same LAT stages, whatever the value of `in_valid`.
- R7: `out_valid` equals `in_valid` delayed by LAT stages. While `out_valid` is 0, `out_y`, `out_c` and `out_cphase` are all 0.
- R8: A synchronous active-high `rst` clears every pipeline stage, so all outputs are 0 from the first edge with `rst` high. After reset the first valid pixel is taken as a U pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_y | input | DW | Luma of the incoming pixel |
| in_u | input | DW | U chroma of the incoming pixel |
| in_v | input | DW | V chroma of the incoming pixel |
| in_hs | input | 1 | Horizontal sync marker of the incoming pixel |
| in_valid | input | 1 | Incoming pixel is valid |
| out_y | output | DW | Luma lane |
| out_c | output | DW | Interleaved chroma lane |
| out_hs | output | 1 | Delayed sync marker |
| out_valid | output | 1 | Delayed valid flag |
| out_cphase | output | 1 | 0 when the chroma lane holds U, 1 when it holds V |

## Verification
Every result is due exactly LAT-1 rising edges after the edge that samples the stimulus (eight register stages). This holds for sync, for valid, for the data lanes and for the phase flag, and it holds on invalid cycles as well. The driver stamps each expected item with the index of the edge that samples it. The monitor compares an item only at the falling edge that follows edge stamp+7, so it samples half a clock away from the edge at which the outputs change. The sequences include lines with gaps in valid, a sync rising edge on an invalid cycle, a sync rising edge right after an odd-length line, and a reset in the middle of a line.

// File: rtl/fmt422_pkg.sv
package fmt422_pkg;

  // Chroma slot carried on the interleaved lane.
  typedef enum logic {
    PH_U = 1'b0,
    PH_V = 1'b1
  } chroma_ph_e;

  // Width of one packed pipeline slot: valid, hs, phase, luma, chroma.
  function automatic int slot_width(input int dw);
    return 3 + 2 * dw;
  endfunction

endpackage

// File: rtl/fmt422_pair.sv
// First stage: picks the chroma byte for each pixel and registers it with
// luma, sync and valid.
module fmt422_pair
  import fmt422_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] u_i,
  input  logic [DW-1:0] v_i,
  input  logic          hs_i,
  input  logic          valid_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o,
  output logic          hs_o,
  output logic          valid_o,
  output logic          ph_o
);

  logic          hs_q;
  logic          hs_rise;
  chroma_ph_e    nxt_ph;
  chroma_ph_e    eff_ph;
  logic [DW-1:0] held_v;

  // A new line forces the current or next valid pixel into the U slot.
  assign hs_rise = hs_i & ~hs_q;

  always_comb begin
    eff_ph = nxt_ph;
    if (hs_rise) eff_ph = PH_U;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q    <= 1'b0;
      nxt_ph  <= PH_U;
      held_v  <= '0;
      y_o     <= '0;
      c_o     <= '0;
      hs_o    <= 1'b0;
      valid_o <= 1'b0;
      ph_o    <= 1'b0;
    end else begin
      hs_q    <= hs_i;
      hs_o    <= hs_i;
      valid_o <= valid_i;
      if (valid_i) begin
        y_o  <= y_i;
        ph_o <= eff_ph;
        if (eff_ph == PH_U) begin
          c_o    <= u_i;
          held_v <= v_i;
          nxt_ph <= PH_V;
        end else begin
          c_o    <= held_v;
          nxt_ph <= PH_U;
        end
      end else begin
        y_o    <= '0;
        c_o    <= '0;
        ph_o   <= 1'b0;
        nxt_ph <= eff_ph;
      end
    end
  end

endmodule

// File: rtl/fmt422_delay.sv
// Plain register delay line with synchronous clear.
module fmt422_delay #(
  parameter int W     = 19,
  parameter int DEPTH = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end

      assign q_o = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/fmt422_out.sv
// 4:4:4 to 4:2:2 output formatter with LAT register stages end to end.
module fmt422_out
  import fmt422_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LAT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_u,
  input  logic [DW-1:0] in_v,
  input  logic          in_hs,
  input  logic          in_valid,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_c,
  output logic          out_hs,
  output logic          out_valid,
  output logic          out_cphase
);

  localparam int SW   = slot_width(DW);
  localparam int TAIL = (LAT > 1) ? LAT - 1 : 0;

  logic [DW-1:0] s1_y;
  logic [DW-1:0] s1_c;
  logic          s1_hs;
  logic          s1_valid;
  logic          s1_ph;
  logic [SW-1:0] s1_slot;
  logic [SW-1:0] out_slot;

  fmt422_pair #(.DW(DW)) u_pair (
    .clk     (clk),
    .rst     (rst),
    .y_i     (in_y),
    .u_i     (in_u),
    .v_i     (in_v),
    .hs_i    (in_hs),
    .valid_i (in_valid),
    .y_o     (s1_y),
    .c_o     (s1_c),
    .hs_o    (s1_hs),
    .valid_o (s1_valid),
    .ph_o    (s1_ph)
  );

  assign s1_slot = {s1_valid, s1_hs, s1_ph, s1_y, s1_c};

  fmt422_delay #(.W(SW), .DEPTH(TAIL)) u_tail (
    .clk (clk),
    .rst (rst),
    .d_i (s1_slot),
    .q_o (out_slot)
  );

  assign {out_valid, out_hs, out_cphase, out_y, out_c} = out_slot;

endmodule

// File: rtl/fmt422_chk.sv
// Property checker, bound to the top module.
module fmt422_chk #(
  parameter int DW  = 8,
  parameter int LAT = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] in_y,
  input logic          in_hs,
  input logic          in_valid,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_c,
  input logic          out_hs,
  input logic          out_valid,
  input logic          out_cphase
);

  logic [DW-1:0] y_sr  [LAT];
  logic          hs_sr [LAT];
  logic          vl_sr [LAT];
  logic          rst_q;
  logic          last_u;
  logic          armed;
  logic          ohs_q;
  logic          orise;

  assign orise = out_hs & ~ohs_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin
        y_sr[i]  <= '0;
        hs_sr[i] <= 1'b0;
        vl_sr[i] <= 1'b0;
      end
      last_u <= 1'b0;
      armed  <= 1'b0;
      ohs_q  <= 1'b0;
    end else begin
      y_sr[0]  <= in_y;
      hs_sr[0] <= in_hs;
      vl_sr[0] <= in_valid;
      for (int i = 1; i < LAT; i++) begin
        y_sr[i]  <= y_sr[i-1];
        hs_sr[i] <= hs_sr[i-1];
        vl_sr[i] <= vl_sr[i-1];
      end
      ohs_q <= out_hs;
      if (out_valid) begin
        last_u <= ~out_cphase;
        armed  <= 1'b0;
      end else if (orise) begin
        armed <= 1'b1;
      end
    end
  end

  AST_LUMA_ALIGN: assert property (@(posedge clk) disable iff (rst)
    vl_sr[LAT-1] |-> out_y == y_sr[LAT-1]); // R1
  AST_V_AFTER_U: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cphase) |-> last_u); // R4
  AST_LINE_STARTS_U: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (armed || orise)) |-> !out_cphase); // R5
  AST_HS_ALIGN: assert property (@(posedge clk) disable iff (rst)
    out_hs == hs_sr[LAT-1]); // R6
  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
    out_valid == vl_sr[LAT-1]); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_y == '0 && out_c == '0 && !out_cphase)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst_q |-> (!out_valid && !out_hs && out_y == '0 && out_c == '0)); // R8

endmodule

bind fmt422_out fmt422_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_y       (in_y),
  .in_hs      (in_hs),
  .in_valid   (in_valid),
  .out_y      (out_y),
  .out_c      (out_c),
  .out_hs     (out_hs),
  .out_valid  (out_valid),
  .out_cphase (out_cphase)
);

// File: tb/fmt422_out_test.sv
`timescale 1ns/1ps
module fmt422_out_test;

  localparam int DW  = 8;
  localparam int LAT = 8;

  typedef struct {
    int          stamp;
    logic        v;
    logic        hs;
    logic        ph;
    logic [7:0]  y;
    logic [7:0]  c;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] in_y = '0, in_u = '0, in_v = '0;
  logic          in_hs = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] out_y, out_c;
  logic          out_hs, out_valid, out_cphase;

  int   edge_cnt = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  // model state
  logic       m_hs_prev = 1'b0;
  logic       m_next_v  = 1'b0;
  logic [7:0] m_held    = '0;

  fmt422_out #(.DW(DW), .LAT(LAT)) uut (
    .clk(clk), .rst(rst), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .in_hs(in_hs), .in_valid(in_valid), .out_y(out_y), .out_c(out_c),
    .out_hs(out_hs), .out_valid(out_valid), .out_cphase(out_cphase)
  );

  always #10 clk = ~clk;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Driver: drives one pixel and pushes the expected result.
  task automatic drive(input logic [7:0] y, input logic [7:0] u, input logic [7:0] v,
                       input logic hs, input logic val);
    exp_t e;
    logic rise, eff_v;
    @(negedge clk);
    #2;
    in_y = y; in_u = u; in_v = v; in_hs = hs; in_valid = val;
    rise = hs && !m_hs_prev;          // R5 line restart
    m_hs_prev = hs;
    eff_v = rise ? 1'b0 : m_next_v;
    e.stamp = edge_cnt + 1;
    e.v  = val;
    e.hs = hs;
    if (val) begin
      e.y  = y;
      e.ph = eff_v;
      if (!eff_v) begin
        e.c = u;                      // R2
        m_held = v;
      end else begin
        e.c = m_held;                 // R3
      end
      m_next_v = !eff_v;              // R4
    end else begin
      e.y = '0; e.c = '0; e.ph = 1'b0;
      m_next_v = eff_v;
    end
    q.push_back(e);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    #2;
    rst = 1'b1;
    in_valid = 1'b0; in_hs = 1'b0;
    q.delete();
    m_hs_prev = 1'b0; m_next_v = 1'b0; m_held = '0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
    check(out_hs == 1'b0, "R8 reset hs", out_hs, 0);
    check(out_y == '0 && out_c == '0, "R8 reset data", {out_y, out_c}, 0);
    @(negedge clk);
    #2;
    rst = 1'b0;
  endtask

  // Monitor: compares each item LAT-1 edges after the edge that sampled it.
  always @(negedge clk) begin
    if (!rst && q.size() > 0 && q[0].stamp == edge_cnt - (LAT - 1)) begin
      exp_t e;
      e = q.pop_front();
      check(out_valid == e.v, "R7 valid", out_valid, e.v);
      check(out_hs == e.hs, "R6 hs", out_hs, e.hs);
      check(out_y == e.y, "R1 R7 luma", out_y, e.y);
      check(out_c == e.c, e.ph ? "R3 chroma V" : "R2 R7 chroma U", out_c, e.c);
      check(out_cphase == e.ph, "R4 R5 R8 phase", out_cphase, e.ph);
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    reset_dut();

    // Line A: sync rise on an idle cycle, then a full even line.
    drive(8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++)
      drive(8'h10 + 8'(i), 8'h80 + 8'(i), 8'hC0 + 8'(i), 1'b0, 1'b1);

    // Line B: sync rise together with a valid pixel, gaps inside pairs.
    drive(8'h20, 8'h90, 8'hD0, 1'b1, 1'b1);
    drive(8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    drive(8'h21, 8'h91, 8'hD1, 1'b0, 1'b1);
    for (int i = 2; i < 9; i++) begin
      if (i % 3 == 0) drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
      drive(8'h20 + 8'(i), 8'h90 + 8'(i), 8'hD0 + 8'(i), 1'b0, 1'b1);
    end

    // Line C: odd count left over, then a new line must restart at U.
    drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    drive(8'h30, 8'hA0, 8'hE0, 1'b1, 1'b1);
    drive(8'h31, 8'hA1, 8'hE1, 1'b0, 1'b1);
    drive(8'h32, 8'hA2, 8'hE2, 1'b0, 1'b1);
    drive(8'h40, 8'hB0, 8'hF0, 1'b1, 1'b1);
    drive(8'h41, 8'hB1, 8'hF1, 1'b1, 1'b1);
    drive(8'h42, 8'hB2, 8'hF2, 1'b0, 1'b1);

    // Reset in mid-line: first pixel afterwards is U.
    drive(8'h50, 8'h5A, 8'h5B, 1'b0, 1'b1);
    reset_dut();
    for (int i = 0; i < 4; i++)
      drive(8'h60 + 8'(i), 8'h70 + 8'(i), 8'hE8 + 8'(i), 1'b0, 1'b1);

    for (int i = 0; i < LAT + 2; i++)
      drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    repeat (LAT + 2) @(negedge clk);
    check(q.size() == 0, "R1 all items delivered", q.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule